// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch address gets its own outcome history. The histories live in a tagged, set-associative history cache. A branch's history, optionally joined with a few low address bits, selects one two-bit saturating counter in a shared table. The upper bit of that counter is the predicted direction. The history cache holds a limited number of branches. When two branches compete for the same slot, the stored tags tell them apart, and a branch that misses starts again from a fixed seed history instead of inheriting another branch's history.

The fetch side sends an address on the predict request channel. The response, which carries the direction, a hit flag and the counter index that was used, appears on the following cycle. When the branch resolves, the back end sends the address, that captured index and the real outcome on the resolve channel. This updates the counter that made the prediction, even if the branch's history has moved on since then. If the branch has a cache entry, its history shifts in the outcome. If it has none, an entry is allocated.

Both request channels use valid/ready. Ready is held high at all times, so a request is accepted in every cycle in which valid is high. The response channel has valid only and cannot be back-pressured: the consumer must take each response in the cycle it is presented. One predict and one resolve can be accepted in the same cycle.

Top module: `ph_local_predictor`

## Requirements
- R1: `pq_ready` and `rs_ready` are always 1. `pr_valid` is 1 in exactly the cycle after a cycle with `pq_valid` high, and 0 after reset.
- R2: `pr_hit` is 1 when a valid way of the set selected by `pq_addr[SET_W+1:2]` holds a tag equal to `pq_addr[ADDR_W-1:SET_W+2]`.
- R3: On a predict miss, the history used for the lookup is the low `HIST_W` bits of 16'hC3FF.
- R4: `pr_index` equals `{history, pq_addr[COL_W+1:2]}`. With `COL_W` = 0 it equals the history alone.
- R5: `pr_taken` is bit 1 of the counter at `pr_index`. Every counter resets to 1, so it predicts not-taken.
- R6: A resolve moves the counter at `rs_index` up by one on taken and down by one on not-taken. The counter saturates at 3 and at 0. The index is used exactly as given.
- R7: A resolve that hits shifts `rs_taken` into bit 0 of that branch's history and drops the oldest bit.
- R8: A resolve that misses allocates a way. The lowest-numbered invalid way is used if there is one; otherwise the least recently used way is replaced. The new entry gets the resolve tag and history `{seed[HIST_W-2:0], rs_taken}`.
- R9: Recency is updated by every predict hit and every allocation. When both happen in one cycle, the allocation counts as the more recent. The victim is chosen from the recency order as it stood before that cycle.
- R10: Reset invalidates every history entry, so the first predict of any address reports a miss.
- R11: A predict and a resolve accepted in the same cycle do not interact: the predict sees the history, valid bits and counters as they were before the resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pq_valid | input | 1 | Predict request valid |
| pq_ready | output | 1 | Predict request ready (always 1) |
| pq_addr | input | ADDR_W | Branch address to predict |
| pr_valid | output | 1 | Prediction response valid |
| pr_taken | output | 1 | Predicted direction (1 = taken) |
| pr_hit | output | 1 | Branch had a history entry |
| pr_index | output | HIST_W+COL_W | Counter index used for this prediction |
| rs_valid | input | 1 | Resolve request valid |
| rs_ready | output | 1 | Resolve request ready (always 1) |
| rs_addr | input | ADDR_W | Resolved branch address |
| rs_index | input | HIST_W+COL_W | Counter index captured from the prediction |
| rs_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
The bench builds two copies of the block with 16-bit addresses, 4-bit histories, 4 sets and 4 ways. One copy uses two column bits and the other uses none, so the shared-column setting runs alongside the address-split setting on the same traffic. With only four sets, a pool of six tags per set forces conflicts and evictions within a few hundred cycles. This makes the choice between an invalid way and the LRU way, and the effect of a same-cycle hit on recency, easy to reach. The 16-entry counter table of the zero-column copy lets the counters reach saturation at both ends quickly, and it also exposes the sharing of counters between branches.

// File: rtl/ph_pkg.sv
`timescale 1ns/1ps
package ph_pkg;
  // Seed history for a freshly allocated or missing branch; low HIST_W bits are used.
  localparam logic [15:0] SEED_PATTERN = 16'hC3FF;
endpackage

// File: rtl/ph_age_touch.sv
`timescale 1ns/1ps
// Makes one way the most recent (age 0) and ages every way that was younger than it.
module ph_age_touch #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
)(
  input  logic [WAYS-1:0][WAY_W-1:0] age_in,
  input  logic                       en,
  input  logic [WAY_W-1:0]           way,
  output logic [WAYS-1:0][WAY_W-1:0] age_out
);
  logic [WAY_W-1:0] ref_age;
  assign ref_age = age_in[way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (!en)
        age_out[w] = age_in[w];
      else if (WAY_W'(w) == way)
        age_out[w] = '0;
      else if (age_in[w] < ref_age)
        age_out[w] = age_in[w] + 1'b1;
      else
        age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/ph_ctr_table.sv
`timescale 1ns/1ps
module ph_ctr_table #(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  logic [1:0] ctr_q [DEPTH];
  logic [1:0] wr_cur, wr_nxt;

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_cur = ctr_q[wr_idx];

  always_comb begin
    wr_nxt = wr_cur;
    if (wr_taken && wr_cur != 2'b11) wr_nxt = wr_cur + 2'd1;
    if (!wr_taken && wr_cur != 2'b00) wr_nxt = wr_cur - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'b01;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_nxt;
    end
  end

  AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_cur != 2'b11 |=> ctr_q[$past(wr_idx)] == $past(wr_cur) + 2'd1); // R6
  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_cur == 2'b11 |=> ctr_q[$past(wr_idx)] == 2'b11); // R6
  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && wr_cur == 2'b00 |=> ctr_q[$past(wr_idx)] == 2'b00); // R6
endmodule

// File: rtl/ph_hist_cache.sv
`timescale 1ns/1ps
module ph_hist_cache
  import ph_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int HIST_W = 10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W - 2;
  localparam logic [HIST_W-1:0] SEED = SEED_PATTERN[HIST_W-1:0];

  typedef logic [WAYS-1:0][WAY_W-1:0] age_vec_t;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [HIST_W-1:0] hist_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  age_vec_t          age_q  [SETS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_match, up_match;
  logic [WAY_W-1:0] lk_way, up_way, vic_way;
  logic             up_hit, up_alloc, lk_touch, vic_found;
  age_vec_t         age_t1, age_base_up, age_t2;
  logic             unused_lo;

  assign unused_lo = ^{lk_addr[1:0], up_addr[1:0]};
  assign lk_set = lk_addr[SET_W+1:2];
  assign lk_tag = lk_addr[ADDR_W-1:SET_W+2];
  assign up_set = up_addr[SET_W+1:2];
  assign up_tag = up_addr[ADDR_W-1:SET_W+2];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      assign up_match[w] = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
    end
  endgenerate

  always_comb begin
    lk_way = '0;
    up_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) lk_way = WAY_W'(w);
      if (up_match[w]) up_way = WAY_W'(w);
    end
  end

  assign lk_hit   = |lk_match;
  assign lk_hist  = lk_hit ? hist_q[lk_set][lk_way] : SEED;
  assign up_hit   = |up_match;
  assign up_alloc = up_en && !up_hit;
  assign lk_touch = lk_en && lk_hit;

  // Victim: lowest invalid way, otherwise the oldest way, from the state before this cycle.
  always_comb begin
    vic_found = 1'b0;
    vic_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vic_found && !vld_q[up_set][w]) begin
        vic_way   = WAY_W'(w);
        vic_found = 1'b1;
      end
    end
    if (!vic_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[up_set][w] == WAY_W'(WAYS-1)) vic_way = WAY_W'(w);
      end
    end
  end

  // Predict-hit touch first, allocation touch on top of it when the sets coincide.
  ph_age_touch #(.WAYS(WAYS)) u_touch_lk (
    .age_in (age_q[lk_set]),
    .en     (lk_touch),
    .way    (lk_way),
    .age_out(age_t1)
  );

  assign age_base_up = (up_set == lk_set) ? age_t1 : age_q[up_set];

  ph_age_touch #(.WAYS(WAYS)) u_touch_up (
    .age_in (age_base_up),
    .en     (up_alloc),
    .way    (vic_way),
    .age_out(age_t2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          hist_q[s][w] <= '0;
          age_q[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      if (lk_touch) age_q[lk_set] <= age_t1;
      if (up_alloc) begin
        age_q[up_set]           <= age_t2;
        tag_q[up_set][vic_way]  <= up_tag;
        vld_q[up_set][vic_way]  <= 1'b1;
        hist_q[up_set][vic_way] <= {SEED[HIST_W-2:0], up_taken};
      end else if (up_en) begin
        hist_q[up_set][up_way] <= {hist_q[up_set][up_way][HIST_W-2:0], up_taken};
      end
    end
  end

  AST_ONE_WAY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R2
  AST_ALLOC_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    up_alloc |=> vld_q[$past(up_set)][$past(vic_way)]); // R8
  AST_ALLOC_STORES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    up_alloc |=> tag_q[$past(up_set)][$past(vic_way)] == $past(up_tag)); // R8

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_perm
      logic [WAYS-1:0] seen;
      always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++) seen[age_q[s][w]] = 1'b1;
      end
      AST_AGES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        &seen); // R9
    end
  endgenerate
endmodule

// File: rtl/ph_local_predictor.sv
`timescale 1ns/1ps
module ph_local_predictor
  import ph_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 10,
  parameter int COL_W  = 0,
  parameter int SETS   = 32,
  parameter int WAYS   = 4
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pq_valid,
  output logic                    pq_ready,
  input  logic [ADDR_W-1:0]       pq_addr,
  output logic                    pr_valid,
  output logic                    pr_taken,
  output logic                    pr_hit,
  output logic [HIST_W+COL_W-1:0] pr_index,
  input  logic                    rs_valid,
  output logic                    rs_ready,
  input  logic [ADDR_W-1:0]       rs_addr,
  input  logic [HIST_W+COL_W-1:0] rs_index,
  input  logic                    rs_taken
);
  localparam int IDX_W = HIST_W + COL_W;
  localparam logic [HIST_W-1:0] SEED = SEED_PATTERN[HIST_W-1:0];

  logic              pq_fire, rs_fire, lk_hit;
  logic [HIST_W-1:0] lk_hist;
  logic [IDX_W-1:0]  lk_idx;
  logic [1:0]        lk_ctr;

  assign pq_ready = 1'b1;
  assign rs_ready = 1'b1;
  assign pq_fire  = pq_valid && pq_ready;
  assign rs_fire  = rs_valid && rs_ready;

  ph_hist_cache #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .HIST_W(HIST_W)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_en   (pq_fire),
    .lk_addr (pq_addr),
    .lk_hit  (lk_hit),
    .lk_hist (lk_hist),
    .up_en   (rs_fire),
    .up_addr (rs_addr),
    .up_taken(rs_taken)
  );

  generate
    if (COL_W == 0) begin : g_shared_col
      assign lk_idx = lk_hist;
    end else begin : g_addr_col
      assign lk_idx = {lk_hist, pq_addr[COL_W+1:2]};
    end
  endgenerate

  ph_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lk_idx),
    .rd_ctr  (lk_ctr),
    .wr_en   (rs_fire),
    .wr_idx  (rs_index),
    .wr_taken(rs_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid <= 1'b0;
      pr_taken <= 1'b0;
      pr_hit   <= 1'b0;
      pr_index <= '0;
    end else begin
      pr_valid <= pq_fire;
      if (pq_fire) begin
        pr_taken <= lk_ctr[1];
        pr_hit   <= lk_hit;
        pr_index <= lk_idx;
      end
    end
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pq_valid |=> pr_valid); // R1
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !pq_valid |=> !pr_valid); // R1
  AST_MISS_USES_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_hit |-> pr_index[IDX_W-1:COL_W] == SEED); // R3
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pq_ready && rs_ready); // R1
endmodule

// File: tb/sim_ph_local_predictor.sv
`timescale 1ns/1ps
module sim_ph_local_predictor;
  localparam int AW = 16, HW = 4, NS = 4, NW = 4, C0 = 2, C1 = 0;
  localparam int I0W = HW + C0, I1W = HW + C1;
  localparam int HMASK = (1 << HW) - 1;
  localparam int SEEDV = 'hC3FF & HMASK;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           pq_valid = 0, rs_valid = 0, rs_taken = 0;
  logic [AW-1:0]  pq_addr = '0, rs_addr = '0;
  logic [I0W-1:0] rs_index0 = '0;
  logic [I1W-1:0] rs_index1 = '0;
  logic pq_ready0, rs_ready0, pr_valid0, pr_taken0, pr_hit0;
  logic pq_ready1, rs_ready1, pr_valid1, pr_taken1, pr_hit1;
  logic [I0W-1:0] pr_index0;
  logic [I1W-1:0] pr_index1;

  ph_local_predictor #(.ADDR_W(AW), .HIST_W(HW), .COL_W(C0), .SETS(NS), .WAYS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .pq_valid(pq_valid), .pq_ready(pq_ready0), .pq_addr(pq_addr),
    .pr_valid(pr_valid0), .pr_taken(pr_taken0), .pr_hit(pr_hit0), .pr_index(pr_index0),
    .rs_valid(rs_valid), .rs_ready(rs_ready0), .rs_addr(rs_addr), .rs_index(rs_index0),
    .rs_taken(rs_taken));

  ph_local_predictor #(.ADDR_W(AW), .HIST_W(HW), .COL_W(C1), .SETS(NS), .WAYS(NW)) u1 (
    .clk(clk), .rst_n(rst_n), .pq_valid(pq_valid), .pq_ready(pq_ready1), .pq_addr(pq_addr),
    .pr_valid(pr_valid1), .pr_taken(pr_taken1), .pr_hit(pr_hit1), .pr_index(pr_index1),
    .rs_valid(rs_valid), .rs_ready(rs_ready1), .rs_addr(rs_addr), .rs_index(rs_index1),
    .rs_taken(rs_taken));

  // Behavioural reference: recency lists instead of ages, plain integer arrays.
  bit m_vld  [NS][NW];
  int m_tag  [NS][NW];
  int m_hist [NS][NW];
  int m_ord  [NS][$];
  int m_c0   [1 << I0W];
  int m_c1   [1 << I1W];
  bit e_v = 0, e_hit = 0, e_t0 = 0, e_t1 = 0;
  int e_i0 = 0, e_i1 = 0, last_i0 = 0, last_i1 = 0;
  int n_chk = 0, n_err = 0;

  typedef struct { int a; int i0; int i1; } pend_t;
  pend_t pend[$];

  function automatic int set_of(int a); return (a >> 2) % NS; endfunction
  function automatic int tag_of(int a); return a >> 4; endfunction
  function automatic int find(int s, int t);
    for (int w = 0; w < NW; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction
  function automatic void touch(int s, int w);
    for (int k = 0; k < m_ord[s].size(); k++)
      if (m_ord[s][k] == w) begin m_ord[s].delete(k); break; end
    m_ord[s].push_front(w);
  endfunction
  function automatic int sat(int c, bit t);
    if (t) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(pr_valid0 == e_v, "R1 u0 response valid", pr_valid0, e_v);
    chk(pr_valid1 == e_v, "R1 u1 response valid", pr_valid1, e_v);
    if (e_v) begin
      chk(pr_hit0 == e_hit, "R2/R8/R9/R10 u0 hit", pr_hit0, e_hit);
      chk(pr_hit1 == e_hit, "R2/R8/R9/R10 u1 hit", pr_hit1, e_hit);
      chk(pr_index0 == e_i0, "R3/R4/R7/R11 u0 index", pr_index0, e_i0);
      chk(pr_index1 == e_i1, "R3/R4/R7/R11 u1 index (zero columns)", pr_index1, e_i1);
      chk(pr_taken0 == e_t0, "R5/R6 u0 direction", pr_taken0, e_t0);
      chk(pr_taken1 == e_t1, "R5/R6 u1 direction", pr_taken1, e_t1);
    end
  endtask

  task automatic step(bit pv, int pa, bit rv, int ra, int ri0, int ri1, bit rt);
    int ps, pw, h, rsi, rw, vic;
    @(negedge clk);
    compare();
    pq_valid = pv; pq_addr = pa[AW-1:0];
    rs_valid = rv; rs_addr = ra[AW-1:0]; rs_taken = rt;
    rs_index0 = ri0[I0W-1:0]; rs_index1 = ri1[I1W-1:0];
    // lookup sees pre-cycle state (R11)
    ps = set_of(pa); pw = find(ps, tag_of(pa));
    h = (pw >= 0) ? m_hist[ps][pw] : SEEDV;
    e_v = pv;
    if (pv) begin
      e_hit = (pw >= 0);
      e_i0 = (h << C0) | ((pa >> 2) & ((1 << C0) - 1));
      e_i1 = h;
      e_t0 = (m_c0[e_i0] >= 2);
      e_t1 = (m_c1[e_i1] >= 2);
      last_i0 = e_i0; last_i1 = e_i1;
    end
    rsi = set_of(ra); rw = -1; vic = -1;
    if (rv) begin
      rw = find(rsi, tag_of(ra));
      if (rw < 0) begin
        for (int w = 0; w < NW; w++) if (vic < 0 && !m_vld[rsi][w]) vic = w;
        if (vic < 0) vic = m_ord[rsi][$];
      end
    end
    if (pv && pw >= 0) touch(ps, pw);
    if (rv) begin
      if (rw >= 0) m_hist[rsi][rw] = ((m_hist[rsi][rw] << 1) | rt) & HMASK;
      else begin
        m_vld[rsi][vic] = 1; m_tag[rsi][vic] = tag_of(ra);
        m_hist[rsi][vic] = ((SEEDV << 1) | rt) & HMASK;
        touch(rsi, vic);
      end
      m_c0[ri0] = sat(m_c0[ri0], rt);
      m_c1[ri1] = sat(m_c1[ri1], rt);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int A, B, ia0, ia1, pa, ra, kind;
    pend_t p;
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin m_vld[s][w] = 0; m_ord[s].push_back(w); end
    end
    foreach (m_c0[i]) m_c0[i] = 1;
    foreach (m_c1[i]) m_c1[i] = 1;
    repeat (3) @(negedge clk);
    // R1 R10 reset state
    chk(pr_valid0 == 0 && pr_valid1 == 0, "R1 reset response idle", pr_valid0, 0);
    chk(pq_ready0 && rs_ready0 && pq_ready1 && rs_ready1, "R1 ready held high", pq_ready0, 1);
    rst_n = 1'b1;

    A = 'h0010; B = 'h0100;
    step(1, A, 0, 0, 0, 0, 0);            // R10 first predict misses, R3 seed index
    ia0 = last_i0; ia1 = last_i1;
    step(0, 0, 1, A, ia0, ia1, 0);        // R8 allocate with not-taken
    step(1, A, 0, 0, 0, 0, 0);            // R7 hit with shifted history
    for (int k = 0; k < 5; k++) step(0, 0, 1, A, ia0, ia1, 1);  // R6 saturate at 3
    step(1, B, 0, 0, 0, 0, 0);            // R5 miss of B reads the seed counter
    step(0, 0, 1, A, ia0, ia1, 0);
    step(1, B, 0, 0, 0, 0, 0);
    step(0, 0, 1, A, ia0, ia1, 0);
    step(1, B, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(0, 0, 1, A, ia0, ia1, 0);  // R6 saturate at 0
    step(1, B, 0, 0, 0, 0, 0);
    // R9 eviction in set 1: allocate four, touch the first, allocate a fifth
    for (int k = 1; k <= 4; k++) step(0, 0, 1, (k << 4) | 4, 0, 0, 1);
    step(1, (1 << 4) | 4, 0, 0, 0, 0, 0);
    step(0, 0, 1, (5 << 4) | 4, 0, 0, 0);
    step(1, (2 << 4) | 4, 0, 0, 0, 0, 0);
    step(1, (1 << 4) | 4, 0, 0, 0, 0, 0);
    step(1, (3 << 4) | 4, 0, 0, 0, 0, 0);
    // R9 same-cycle hit and allocation in one set
    step(1, (1 << 4) | 4, 1, (6 << 4) | 4, 0, 0, 1);
    // R11 same-cycle predict and resolve of one branch
    step(1, A, 1, A, 3, 3, 1);
    step(1, (7 << 4) | 8, 1, (7 << 4) | 8, 0, 0, 1);
    step(1, (7 << 4) | 8, 0, 0, 0, 0, 0);

    for (int c = 0; c < 4000; c++) begin
      bit pv, rv, rt;
      pv = ($urandom % 4) != 0;
      pa = (($urandom % 6 + 1) << 4) | (($urandom % NS) << 2);
      rv = (pend.size() > 0) && (($urandom % 3) != 0);
      ra = 0; ia0 = 0; ia1 = 0; rt = 0;
      if (rv) begin
        p = pend.pop_front();
        ra = p.a; ia0 = p.i0; ia1 = p.i1;
        kind = (ra >> 4) % 3;
        rt = (kind == 0) ? 1'b1 : (kind == 1) ? 1'b0 : 1'($urandom % 2);
      end
      step(pv, pa, rv, ra, ia0, ia1, rt);
      if (pv) pend.push_back('{a: pa, i0: last_i0, i1: last_i1});
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    summary();
    $finish;
  end
endmodule